// File: doc/BRIEF.md
# 40-bit Signed Multiply-Accumulate Unit

This block holds one 40-bit accumulator and adds signed products into it. An operation is given as a 3-bit code with two 32-bit source words. Four of the codes form one 16x16 product. Each code picks the upper or lower half-word of each source on its own, and the 32-bit product is sign-extended before it is added. A dual code adds both the upper-by-upper and lower-by-lower products in one step. A wide code adds the low 40 bits of the full signed 32x32 product.

Two further codes move data between the accumulator and a pair of 32-bit words. One loads the accumulator from a pair of words. The other returns its contents as a low word and a sign-extended high word. All arithmetic wraps modulo 2^40. The issuing side presents an operation with `op_valid`. It watches `busy` to know when the unit can take another, and `res_valid` to know when an operation has completed.

Top module: `mac40_unit`

## Requirements
- R1: After a synchronous active-low reset, `acc_out`, `busy`, `res_valid`, `res_lo` and `res_hi` are all zero.
- R2: Codes 0 to 3 are 16x16 multiplies. Code bit 1 set takes `src_a[31:16]`, clear takes `src_a[15:0]`. Code bit 0 picks the half of `src_b` in the same way. The signed 32-bit product, sign-extended to 40 bits, is added to the accumulator.
- R3: Code 4 adds both signed products in one operation: `src_a[31:16]*src_b[31:16]` and `src_a[15:0]*src_b[15:0]`, each sign-extended.
- R4: Code 5 adds bits 39:0 of the signed 64-bit product `src_a*src_b`.
- R5: Every addition wraps modulo 2^40 and never saturates.
- R6: Code 6 sets the accumulator to `{src_b[7:0], src_a}`. Bits 31:8 of `src_b` have no effect.
- R7: Code 7 sets `res_lo` to accumulator bits 31:0 and `res_hi` to bits 39:32 sign-extended to 32 bits. The accumulator is left unchanged.
- R8: An operation is accepted on a rising edge where `op_valid` is high and `busy` is low. Codes other than 5 take effect at that edge, and `res_valid` is high for exactly the following cycle.
- R9: After code 5 is accepted, `busy` is high for exactly one cycle. The accumulator is updated at the end of that cycle, and `res_valid` is high in the cycle after.
- R10: An operation presented while `busy` is high is ignored.
- R11: With no accepted operation and no wide multiply pending, the accumulator holds its value and `res_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | An operation is presented |
| op_code | input | 3 | Operation code |
| src_a | input | 32 | First source word (multiplicand, or low word on load) |
| src_b | input | 32 | Second source word (multiplier, or high word on load) |
| busy | output | 1 | A wide multiply is in progress; new operations are refused |
| res_valid | output | 1 | An operation completed at the previous edge |
| res_lo | output | 32 | Low word of the last read-out |
| res_hi | output | 32 | Sign-extended high word of the last read-out |
| acc_out | output | 40 | Current accumulator contents |

## Verification
The handshake assertions assume that `op_code` is a defined value whenever `op_valid` is high. The hold assertions assume that nothing changes the accumulator except an accepted operation or the second cycle of a wide multiply. The stimulus drives every input on falling edges and always presents fully known codes and words. It holds `op_valid` low between operations, except in the single test that deliberately offers an operation while `busy` is high. The sweeps pair corner operands (zero, ±1, the most positive and most negative halves, mixed patterns) across all multiply codes. Results are compared against a 64-bit arithmetic model that is reduced to 40 bits.

// File: rtl/mac40_pkg.sv
// Package: shared operation codes for the 40-bit multiply-accumulate unit.
// Assumes: codes 0..3 encode half-word selection in bits 1 (a) and 0 (b).
package mac40_pkg;
    typedef enum logic [2:0] {
        OP_LL   = 3'd0,
        OP_LH   = 3'd1,
        OP_HL   = 3'd2,
        OP_HH   = 3'd3,
        OP_DUAL = 3'd4,
        OP_WIDE = 3'd5,
        OP_LOAD = 3'd6,
        OP_READ = 3'd7
    } mac_op_e;
endpackage

// File: rtl/mac40_half_mul.sv
// Module: one signed half-word multiplier lane.
// Picks one half of each operand, multiplies them signed and sign-extends
// the full-width product to the accumulator width. Purely combinational.
// Assumes: WORD_W is even and ACC_W >= WORD_W.
module mac40_half_mul #(
    parameter int WORD_W = 32,
    parameter int ACC_W  = 40
) (
    input  logic [WORD_W-1:0] a,
    input  logic [WORD_W-1:0] b,
    input  logic              a_hi,
    input  logic              b_hi,
    output logic [ACC_W-1:0]  prod_ext
);
    localparam int HALF_W = WORD_W / 2;
    localparam int EXT_W  = ACC_W - WORD_W;

    logic signed [HALF_W-1:0] ha;
    logic signed [HALF_W-1:0] hb;
    logic signed [WORD_W-1:0] prod;

    // select halves, multiply signed, extend sign to accumulator width
    always_comb begin
        ha       = a_hi ? a[WORD_W-1:HALF_W] : a[HALF_W-1:0];
        hb       = b_hi ? b[WORD_W-1:HALF_W] : b[HALF_W-1:0];
        prod     = ha * hb;
        prod_ext = {{EXT_W{prod[WORD_W-1]}}, prod};
    end
endmodule

// File: rtl/mac40_wide_mul.sv
// Module: two-cycle signed full-word multiplier, low ACC_W bits only.
// Cycle of start: forms a * unsigned(b low half) and keeps a and b's high half.
// Following cycle: wide_prod = kept partial + (a * signed(b high half)) << HALF_W.
// Assumes: the caller reads wide_prod only in the cycle after start.
module mac40_wide_mul #(
    parameter int WORD_W = 32,
    parameter int ACC_W  = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] a,
    input  logic [WORD_W-1:0] b,
    output logic [ACC_W-1:0]  wide_prod
);
    localparam int HALF_W = WORD_W / 2;

    logic signed [ACC_W-1:0]  part_lo_d;
    logic signed [ACC_W-1:0]  part_lo_q;
    logic signed [WORD_W-1:0] a_q;
    logic signed [HALF_W-1:0] b_hi_q;
    logic signed [ACC_W-1:0]  part_hi;

    // first stage: low partial product, modulo 2^ACC_W
    always_comb begin
        part_lo_d = $signed(a) * $signed({1'b0, b[HALF_W-1:0]});
    end

    // capture the first stage and the operands for the second stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            part_lo_q <= '0;
            a_q       <= '0;
            b_hi_q    <= '0;
        end else if (start) begin
            part_lo_q <= part_lo_d;
            a_q       <= $signed(a);
            b_hi_q    <= $signed(b[WORD_W-1:HALF_W]);
        end
    end

    // second stage: high partial product, shifted and summed
    always_comb begin
        part_hi   = a_q * b_hi_q;
        wide_prod = part_lo_q + (part_hi <<< HALF_W);
    end
endmodule

// File: rtl/mac40_ctrl.sv
// Module: operation handshake for the multiply-accumulate unit.
// Accepts an operation when not busy, holds busy for one cycle on a wide
// multiply and pulses res_valid one cycle after each completion.
// Assumes: op_code is a defined value when op_valid is high.
module mac40_ctrl
    import mac40_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       op_valid,
    input  logic [2:0] op_code,
    output logic       accept,
    output logic       wide_start,
    output logic       wide_finish,
    output logic       busy,
    output logic       res_valid
);
    logic busy_q;
    logic done_q;

    // accept only while idle
    always_comb begin
        accept      = op_valid && !busy_q;
        wide_start  = accept && (op_code == OP_WIDE);
        wide_finish = busy_q;
        busy        = busy_q;
        res_valid   = done_q;
    end

    // busy covers the second cycle of a wide multiply; done marks completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            busy_q <= wide_start;
            done_q <= (accept && !wide_start) || busy_q;
        end
    end

    // R9
    busy_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |=> !busy_q);

    // R9
    busy_then_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |=> done_q);

    // R9
    busy_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_q) |-> $past(op_valid && op_code == OP_WIDE));

    // R11
    idle_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid && !busy_q) |=> !done_q);
endmodule

// File: rtl/mac40_unit.sv
// Module: 40-bit signed multiply-accumulate unit (top).
// Decodes a 3-bit operation, forms 16x16, dual 16x16 or two-cycle 32x32
// signed products, adds them into one wrapping accumulator and moves the
// accumulator to or from a pair of words.
// Assumes: WORD_W < ACC_W <= 2*WORD_W.
module mac40_unit
    import mac40_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int ACC_W  = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [2:0]        op_code,
    input  logic [WORD_W-1:0] src_a,
    input  logic [WORD_W-1:0] src_b,
    output logic              busy,
    output logic              res_valid,
    output logic [WORD_W-1:0] res_lo,
    output logic [WORD_W-1:0] res_hi,
    output logic [ACC_W-1:0]  acc_out
);
    localparam int TOP_W   = ACC_W - WORD_W;
    localparam int LANES   = 2;

    mac_op_e            op;
    logic               accept;
    logic               wide_start;
    logic               wide_finish;
    logic [ACC_W-1:0]   acc_q;
    logic [ACC_W-1:0]   wide_prod;
    logic [ACC_W-1:0]   lane_prod [LANES];
    logic [LANES-1:0]   lane_a_hi;
    logic [LANES-1:0]   lane_b_hi;

    // typed view of the code
    always_comb op = mac_op_e'(op_code);

    // lane 0 follows the code (or high/high for dual); lane 1 is low/low
    always_comb begin
        lane_a_hi[0] = (op == OP_DUAL) ? 1'b1 : op_code[1];
        lane_b_hi[0] = (op == OP_DUAL) ? 1'b1 : op_code[0];
        lane_a_hi[1] = 1'b0;
        lane_b_hi[1] = 1'b0;
    end

    mac40_ctrl i_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .op_valid    (op_valid),
        .op_code     (op_code),
        .accept      (accept),
        .wide_start  (wide_start),
        .wide_finish (wide_finish),
        .busy        (busy),
        .res_valid   (res_valid)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        mac40_half_mul #(.WORD_W(WORD_W), .ACC_W(ACC_W)) i_half (
            .a        (src_a),
            .b        (src_b),
            .a_hi     (lane_a_hi[g]),
            .b_hi     (lane_b_hi[g]),
            .prod_ext (lane_prod[g])
        );
    end

    mac40_wide_mul #(.WORD_W(WORD_W), .ACC_W(ACC_W)) i_wide (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (wide_start),
        .a         (src_a),
        .b         (src_b),
        .wide_prod (wide_prod)
    );

    // accumulator update per accepted operation or wide completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (accept) begin
            unique case (op)
                OP_LL, OP_LH, OP_HL, OP_HH: acc_q <= acc_q + lane_prod[0];
                OP_DUAL: acc_q <= acc_q + lane_prod[0] + lane_prod[1];
                OP_LOAD: acc_q <= {src_b[TOP_W-1:0], src_a};
                default: acc_q <= acc_q;
            endcase
        end else if (wide_finish) begin
            acc_q <= acc_q + wide_prod;
        end
    end

    // read-out register pair, written only by the read code
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_lo <= '0;
            res_hi <= '0;
        end else if (accept && op == OP_READ) begin
            res_lo <= acc_q[WORD_W-1:0];
            res_hi <= {{(WORD_W-TOP_W){acc_q[ACC_W-1]}}, acc_q[ACC_W-1:WORD_W]};
        end
    end

    // expose the accumulator
    always_comb acc_out = acc_q;

    // R11
    acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid && !busy) |=> $stable(acc_q));

    // R7
    read_keeps_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !busy && op_code == OP_READ) |=> $stable(acc_q));

    // R10
    busy_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && op_valid && op_code == OP_READ) |=> $stable(res_lo));
endmodule

// File: tb/test_mac40_unit.sv
module test_mac40_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_code = 3'd0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic        busy;
    logic        res_valid;
    logic [31:0] res_lo;
    logic [31:0] res_hi;
    logic [39:0] acc_out;

    int total = 0;
    int bad = 0;
    logic [39:0] model = '0;
    logic [31:0] vals [6] = '{32'h0000_0000, 32'h0001_FFFF, 32'h7FFF_8000,
                             32'h8000_7FFF, 32'hFFFF_0001, 32'h1234_A5C3};

    always #5 clk = ~clk;

    mac40_unit i_mac40_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .src_a(src_a), .src_b(src_b), .busy(busy), .res_valid(res_valid),
        .res_lo(res_lo), .res_hi(res_hi), .acc_out(acc_out)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [39:0] sx32(input logic [31:0] v);
        return {{8{v[31]}}, v};
    endfunction

    function automatic logic [39:0] half_prod(input logic [31:0] a, input logic [31:0] b,
                                              input bit ahi, input bit bhi);
        logic signed [15:0] ha;
        logic signed [15:0] hb;
        logic signed [31:0] p;
        ha = ahi ? a[31:16] : a[15:0];
        hb = bhi ? b[31:16] : b[15:0];
        p  = ha * hb;
        return sx32(p);
    endfunction

    // issue one operation and wait for its completion window
    task automatic run_op(input logic [2:0] code, input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        op_valid = 1'b1; op_code = code; src_a = a; src_b = b;
        @(negedge clk);
        op_valid = 1'b0;
        if (code == 3'd5) begin
            chk(busy === 1'b1 && res_valid === 1'b0, "R9 busy after wide", {busy, res_valid}, 2'b10);
            @(negedge clk);
            chk(busy === 1'b0, "R9 busy single cycle", busy, 0);
        end
        chk(res_valid === 1'b1, "R8 res_valid pulse", res_valid, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=%h expected=%h", 0, 1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk(acc_out === 0 && busy === 0 && res_valid === 0 && res_lo === 0 && res_hi === 0,
            "R1 reset state", {acc_out, busy, res_valid}, 0);

        // R2: all four half selections over corner operands
        for (int s = 0; s < 4; s++)
            for (int i = 0; i < 6; i++)
                for (int j = 0; j < 6; j++) begin
                    run_op(3'(s), vals[i], vals[j]);
                    model = model + half_prod(vals[i], vals[j], s[1], s[0]);
                    chk(acc_out === model, "R2 half select", acc_out, model);
                end

        // R3: dual lane
        for (int i = 0; i < 6; i++)
            for (int j = 0; j < 6; j++) begin
                run_op(3'd4, vals[i], vals[j]);
                model = model + half_prod(vals[i], vals[j], 1, 1) + half_prod(vals[i], vals[j], 0, 0);
                chk(acc_out === model, "R3 dual", acc_out, model);
            end

        // R4: wide multiply
        for (int i = 0; i < 6; i++)
            for (int j = 0; j < 6; j++) begin
                logic signed [63:0] p;
                run_op(3'd5, vals[i], vals[j]);
                p = $signed(vals[i]) * $signed(vals[j]);
                model = model + p[39:0];
                chk(acc_out === model, "R4 wide", acc_out, model);
            end
        begin
            logic signed [63:0] p;
            run_op(3'd5, 32'h8000_0000, 32'h8000_0000);
            p = $signed(32'h8000_0000) * $signed(32'h8000_0000);
            model = model + p[39:0];
            chk(acc_out === model, "R4 wide most negative", acc_out, model);
        end

        // R6: load with junk in upper high bits
        run_op(3'd6, 32'hFFFF_FFFF, 32'hABCD_E07F);
        model = 40'h7F_FFFF_FFFF;
        chk(acc_out === model, "R6 load", acc_out, model);

        // R5: positive wrap
        run_op(3'd0, 32'h1, 32'h1);
        model = 40'h80_0000_0000;
        chk(acc_out === model, "R5 wrap positive", acc_out, model);

        // R7: read out negative accumulator
        run_op(3'd7, 32'h0, 32'h0);
        chk(res_lo === 32'h0 && res_hi === 32'hFFFF_FF80, "R7 read negative",
            {res_hi, res_lo}, 64'hFFFF_FF80_0000_0000);
        chk(acc_out === model, "R7 acc unchanged", acc_out, model);

        // R5: wrap through zero
        run_op(3'd6, 32'hFFFF_FFFF, 32'h0000_00FF);
        run_op(3'd3, 32'h0001_0000, 32'h0001_0000);
        chk(acc_out === 40'h0, "R5 wrap to zero", acc_out, 0);

        // R7: read positive
        run_op(3'd6, 32'h89AB_CDEF, 32'h0000_0012);
        run_op(3'd7, 32'h0, 32'h0);
        chk(res_lo === 32'h89AB_CDEF && res_hi === 32'h12, "R7 read positive",
            {res_hi, res_lo}, 64'h12_89AB_CDEF);
        model = 40'h12_89AB_CDEF;

        // R10: operation offered while busy is ignored
        @(negedge clk);
        op_valid = 1'b1; op_code = 3'd5; src_a = 32'd3; src_b = 32'd5;
        @(negedge clk);
        op_code = 3'd6; src_a = 32'h0; src_b = 32'h0;
        @(negedge clk);
        op_valid = 1'b0;
        model = model + 40'd15;
        chk(acc_out === model, "R10 ignored while busy", acc_out, model);

        // R11: idle hold
        repeat (4) @(negedge clk);
        chk(acc_out === model && res_valid === 1'b0, "R11 idle hold", acc_out, model);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule